// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability Registers

This block holds the configuration-space capability that lets software set up message-signalled interrupts for a function. It offers a byte-addressed register window. Each access moves 1, 2 or 4 bytes, and the value is right-aligned on the data bus. Software programs the enable bit, the number of vectors in use, the message address, the message data and an optional per-vector mask word through this window.

The block then drives one registered descriptor per supported vector. Each descriptor carries the address, that vector's data word and an effective masked flag. An interrupt source uses the descriptor to form its message.

Elaboration parameters choose the options:
- 64-bit addressing.
- Per-vector masking.
- Extended (32-bit) message data.
- The log2 of the vector count the function supports.

These options set the length of the capability and the offsets of its registers. Decoding of host configuration cycles and delivery of the messages on a bus are handled elsewhere.

Top module: `msi_cap_regs`

## Requirements
- R1: The capability length is 12 bytes with neither 64-bit addressing nor masking, 16 with 64-bit addressing only, 20 with masking only, and 24 with both.
  - Without 64-bit addressing: address at 0x4, data at 0x8, mask at 0xC.
  - With 64-bit addressing: low address at 0x4, high address at 0x8, data at 0xC, mask at 0x10.
  - Writes at or beyond the length, and writes to a mask that does not exist, change nothing.
  - Reads of undefined offsets return 0.
- R2: Byte 0 reads the capability ID 0x05 and byte 1 reads the NEXT_PTR parameter. Both are read-only.
  - The 16-bit control word sits at byte 2. Its bit 0 is enable, bits 3:1 are the supported vector log2 (read-only), and bits 6:4 are the enabled vector log2.
  - Bit 7 is the 64-bit option, bit 8 is the mask option and bit 9 is the extended-data option; bits 7 to 9 are read-only.
  - Bit 10 is extended-data enable. Bits 15:11 read 0.
- R3: A write to the enabled vector log2 stores the smaller of the written value and the supported log2. For example, writing 5 with support 3 reads back 3.
- R4: The extended-data enable bit is writable only when the extended-data option is present. Otherwise it reads 0.
- R5: When extended data is not enabled, a data write keeps only bits 15:0, and bits 31:16 read 0. When it is enabled, all 32 bits are kept.
- R6: Every vector carries the programmed address, with the high half 0 when 64-bit addressing is absent. Vector i carries data equal to the base data plus i.
- R7: Vectors with index at or above 2 to the power of the enabled vector log2 are reported masked.
- R8: With masking present, mask bit i forces vector i masked. Mask bits at and above the supported vector count read 0.
- R9: Reset clears the enable bit and every register. While enable is 0, every vector is reported masked.
- R10: The size code 0 selects 1 byte, 1 selects 2 bytes and 2 selects 4 bytes. The access starts at the byte offset given, and write data and read data are right-aligned. A 4-byte write at offset 0 updates the control word from data bits 31:16.
- R11: Read data and the read-valid strobe appear in the cycle after the read request and last one cycle. Descriptor outputs follow a register write one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| addr_i | input | 5 | Byte offset in the capability |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Right-aligned write data |
| rdata_o | output | 32 | Right-aligned read data |
| rd_valid_o | output | 1 | Read data valid |
| vec_addr_o | output | 64*NVEC | Per-vector message address |
| vec_data_o | output | 32*NVEC | Per-vector message data |
| vec_masked_o | output | NVEC | Per-vector effective mask |

## Verification
The hardest state to reach combines three things: a clamped vector count, an active mask bit and a data word shortened by a disabled extended-data bit. Only a particular order of control, data and mask writes reaches it. The bench builds this state step by step with a table of register accesses, including sub-dword writes that land in the middle of the data register. Directed steps then toggle the enabled count and the extended-data bit. After each step the bench compares every descriptor with values computed from the requirements. A second instance with no options shows that the mask offset lies beyond the capability, that the extended-data bit stays 0, and that the data word is cut to 16 bits.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam logic [7:0] CAP_ID = 8'h05;
  // control word bit positions
  localparam int C_EN   = 0;
  localparam int C_XDEN = 10;
  localparam int C_MME  = 4;

  function automatic logic [2:0] clamp3(input logic [2:0] req, input logic [2:0] lim);
    return (req > lim) ? lim : req;
  endfunction
endpackage

// File: rtl/msi_lane_align.sv
module msi_lane_align (
  input  logic [1:0]  off_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] rdword_i,
  output logic [31:0] bmask_o,
  output logic [31:0] wshift_o,
  output logic [31:0] rval_o
);
  logic [3:0]  be;
  logic [31:0] szmask;

  always_comb begin
    case (size_i)
      2'd0:    szmask = 32'h0000_00FF;
      2'd1:    szmask = 32'h0000_FFFF;
      default: szmask = 32'hFFFF_FFFF;
    endcase
    be = 4'b0000;
    for (int b = 0; b < 4; b++) be[b] = szmask[8*b];
    bmask_o  = szmask << {off_i, 3'b000};
    wshift_o = wdata_i << {off_i, 3'b000};
    rval_o   = (rdword_i >> {off_i, 3'b000}) & szmask;
  end
endmodule

// File: rtl/msi_vec_gen.sv
module msi_vec_gen #(
  parameter int NVEC     = 8,
  parameter bit MASK_CAP = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic [2:0]           mme_i,
  input  logic [63:0]          addr_i,
  input  logic [31:0]          data_i,
  input  logic [NVEC-1:0]      mask_i,
  output logic [64*NVEC-1:0]   vec_addr_o,
  output logic [32*NVEC-1:0]   vec_data_o,
  output logic [NVEC-1:0]      vec_masked_o
);
  logic [5:0] lim;
  assign lim = 6'd1 << mme_i;

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (rst) begin
        vec_addr_o[64*g +: 64] <= '0;
        vec_data_o[32*g +: 32] <= '0;
        vec_masked_o[g]        <= 1'b1;
      end else begin
        vec_addr_o[64*g +: 64] <= addr_i;
        vec_data_o[32*g +: 32] <= data_i + 32'(g);
        vec_masked_o[g]        <= !en_i || (6'(g) >= lim) || (MASK_CAP && mask_i[g]);
      end
    end

    a_r7_beyond_count_masked: assert property (@(posedge clk) disable iff (rst)
      (6'(g) >= lim) |=> vec_masked_o[g]);
    a_r8_mask_forces_vector: assert property (@(posedge clk) disable iff (rst)
      (MASK_CAP && mask_i[g]) |=> vec_masked_o[g]);
  end

  a_r9_disabled_all_masked: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (&vec_masked_o));
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs #(
  parameter bit          ADDR64_CAP   = 1'b1,
  parameter bit          MASK_CAP     = 1'b1,
  parameter bit          XDATA_CAP    = 1'b1,
  parameter int          VEC_LOG2     = 3,
  parameter logic [7:0]  NEXT_PTR     = 8'h00,
  localparam int         NVEC         = 1 << VEC_LOG2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [4:0]           addr_i,
  input  logic [1:0]           size_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic                 rd_valid_o,
  output logic [64*NVEC-1:0]   vec_addr_o,
  output logic [32*NVEC-1:0]   vec_data_o,
  output logic [NVEC-1:0]      vec_masked_o
);
  import msi_cap_pkg::*;

  localparam int CAP_LEN = 12 + (ADDR64_CAP ? 4 : 0) + (MASK_CAP ? 8 : 0);
  localparam int DW_DATA = ADDR64_CAP ? 3 : 2;
  localparam int DW_MASK = DW_DATA + 1;
  localparam logic [2:0] VL = 3'(VEC_LOG2);

  logic            en_q, xden_q;
  logic [2:0]      mme_q;
  logic [31:0]     addr_lo_q, addr_hi_q, data_q;
  logic [NVEC-1:0] mask_q;

  logic [2:0]  dw;
  logic        in_rng;
  logic [15:0] ctrl_rd;
  logic [31:0] cur_dword, bmask, wshift, rval, merged;

  assign dw     = addr_i[4:2];
  assign in_rng = int'({addr_i[4:2], 2'b00}) < CAP_LEN;
  assign ctrl_rd = {5'b0, xden_q, XDATA_CAP, MASK_CAP, ADDR64_CAP, mme_q, VL, en_q};

  always_comb begin
    cur_dword = '0;
    if (dw == 3'd0)                                  cur_dword = {ctrl_rd, NEXT_PTR, CAP_ID};
    else if (dw == 3'd1)                             cur_dword = addr_lo_q;
    else if (ADDR64_CAP && dw == 3'd2)               cur_dword = addr_hi_q;
    else if (int'(dw) == DW_DATA)                    cur_dword = data_q;
    else if (MASK_CAP && int'(dw) == DW_MASK)        cur_dword = 32'(mask_q);
  end

  msi_lane_align u_align (
    .off_i   (addr_i[1:0]),
    .size_i  (size_i),
    .wdata_i (wdata_i),
    .rdword_i(cur_dword),
    .bmask_o (bmask),
    .wshift_o(wshift),
    .rval_o  (rval)
  );

  assign merged = (cur_dword & ~bmask) | (wshift & bmask);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      xden_q     <= 1'b0;
      mme_q      <= '0;
      addr_lo_q  <= '0;
      addr_hi_q  <= '0;
      data_q     <= '0;
      mask_q     <= '0;
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rval;
      if (wr_en_i && in_rng) begin
        if (dw == 3'd0) begin
          en_q   <= merged[16 + C_EN];
          mme_q  <= clamp3(merged[16 + C_MME +: 3], VL);
          xden_q <= XDATA_CAP & merged[16 + C_XDEN];
        end else if (dw == 3'd1) begin
          addr_lo_q <= merged;
        end else if (ADDR64_CAP && dw == 3'd2) begin
          addr_hi_q <= merged;
        end else if (int'(dw) == DW_DATA) begin
          data_q <= xden_q ? merged : {16'h0000, merged[15:0]};
        end else if (MASK_CAP && int'(dw) == DW_MASK) begin
          mask_q <= merged[NVEC-1:0];
        end
      end
    end
  end

  msi_vec_gen #(.NVEC(NVEC), .MASK_CAP(MASK_CAP)) u_vec (
    .clk         (clk),
    .rst         (rst),
    .en_i        (en_q),
    .mme_i       (mme_q),
    .addr_i      ({addr_hi_q, addr_lo_q}),
    .data_i      (data_q),
    .mask_i      (mask_q),
    .vec_addr_o  (vec_addr_o),
    .vec_data_o  (vec_data_o),
    .vec_masked_o(vec_masked_o)
  );

  a_r11_read_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
  a_r1_oob_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !in_rng) |=> ($stable(data_q) && $stable(en_q) && $stable(mme_q) && $stable(mask_q)));
  a_r3_mme_within_cap: assert property (@(posedge clk) disable iff (rst)
    mme_q <= VL);
endmodule

// File: tb/sim_msi_cap_regs.sv
module sim_msi_cap_regs;
  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [7:0]  rq;
  } step_t;

  localparam int NSTEP = 23;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 5'h00, 2'd2, 32'h0,          32'h0386_8005, 8'd2},  // R2 id, next, control
    '{1'b0, 5'h01, 2'd0, 32'h0,          32'h0000_0080, 8'd2},  // R2 next pointer
    '{1'b0, 5'h02, 2'd1, 32'h0,          32'h0000_0386, 8'd2},  // R2 control word
    '{1'b1, 5'h04, 2'd2, 32'hC000_D000,  32'h0,         8'd1},
    '{1'b0, 5'h04, 2'd2, 32'h0,          32'hC000_D000, 8'd1},  // R1 low address
    '{1'b1, 5'h08, 2'd2, 32'h0000_0001,  32'h0,         8'd1},
    '{1'b0, 5'h08, 2'd2, 32'h0,          32'h0000_0001, 8'd1},  // R1 high address
    '{1'b1, 5'h02, 2'd1, 32'h0000_0451,  32'h0,         8'd3},
    '{1'b0, 5'h02, 2'd1, 32'h0,          32'h0000_07B7, 8'd3},  // R3 clamp, R4 bit kept
    '{1'b1, 5'h0C, 2'd2, 32'h00AA_CC00,  32'h0,         8'd5},
    '{1'b0, 5'h0C, 2'd2, 32'h0,          32'h00AA_CC00, 8'd5},  // R5 full data
    '{1'b1, 5'h10, 2'd2, 32'h0000_0302,  32'h0,         8'd8},
    '{1'b0, 5'h10, 2'd2, 32'h0,          32'h0000_0002, 8'd8},  // R8 mask upper bits zero
    '{1'b0, 5'h14, 2'd2, 32'h0,          32'h0,         8'd1},  // R1 undefined reads zero
    '{1'b1, 5'h18, 2'd2, 32'hFFFF_FFFF,  32'h0,         8'd1},
    '{1'b0, 5'h18, 2'd2, 32'h0,          32'h0,         8'd1},  // R1 beyond length
    '{1'b1, 5'h00, 2'd0, 32'h0000_0000,  32'h0,         8'd2},
    '{1'b0, 5'h00, 2'd0, 32'h0,          32'h0000_0005, 8'd2},  // R2 id read-only
    '{1'b1, 5'h0D, 2'd0, 32'h0000_0011,  32'h0,         8'd10},
    '{1'b0, 5'h0C, 2'd2, 32'h0,          32'h00AA_1100, 8'd10}, // R10 byte lane write
    '{1'b0, 5'h0E, 2'd0, 32'h0,          32'h0000_00AA, 8'd10}, // R10 byte read
    '{1'b1, 5'h0C, 2'd2, 32'h00AA_CC00,  32'h0,         8'd10},
    '{1'b0, 5'h08, 2'd1, 32'h0,          32'h0000_0001, 8'd10}  // R10 halfword read
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr0 = 0, rd0 = 0, wr1 = 0, rd1 = 0;
  logic [4:0] addr = '0;
  logic [1:0] sz = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata0, rdata1;
  logic rv0, rv1;
  logic [64*8-1:0] va0;  logic [32*8-1:0] vd0;  logic [7:0] vm0;
  logic [64*4-1:0] va1;  logic [32*4-1:0] vd1;  logic [3:0] vm1;
  int n_chk = 0, n_err = 0, cyc = 0;
  logic [31:0] got;

  always #4 clk = ~clk;

  msi_cap_regs #(.ADDR64_CAP(1), .MASK_CAP(1), .XDATA_CAP(1), .VEC_LOG2(3), .NEXT_PTR(8'h80)) u0 (
    .clk(clk), .rst(rst), .wr_en_i(wr0), .rd_en_i(rd0), .addr_i(addr), .size_i(sz),
    .wdata_i(wd), .rdata_o(rdata0), .rd_valid_o(rv0),
    .vec_addr_o(va0), .vec_data_o(vd0), .vec_masked_o(vm0));

  msi_cap_regs #(.ADDR64_CAP(0), .MASK_CAP(0), .XDATA_CAP(0), .VEC_LOG2(2)) u1 (
    .clk(clk), .rst(rst), .wr_en_i(wr1), .rd_en_i(rd1), .addr_i(addr), .size_i(sz),
    .wdata_i(wd), .rdata_o(rdata1), .rd_valid_o(rv1),
    .vec_addr_o(va1), .vec_data_o(vd1), .vec_masked_o(vm1));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input bit which, input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    addr = a; sz = s; wd = d;
    if (which) wr1 = 1'b1; else wr0 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic do_rd(input bit which, input logic [4:0] a, input logic [1:0] s, output logic [31:0] q);
    @(negedge clk);
    addr = a; sz = s;
    if (which) rd1 = 1'b1; else rd0 = 1'b1;
    @(negedge clk);
    rd0 = 1'b0; rd1 = 1'b0;
    q = which ? rdata1 : rdata0;
    chk("R11 read valid strobe", 64'(which ? rv1 : rv0), 64'd1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset vectors masked", 64'(vm0), 64'hFF);
    chk("R11 no strobe without read", 64'(rv0), 64'd0);

    for (int k = 0; k < NSTEP; k++) begin
      if (STEPS[k].wr) do_wr(1'b0, STEPS[k].addr, STEPS[k].sz, STEPS[k].wd);
      else begin
        do_rd(1'b0, STEPS[k].addr, STEPS[k].sz, got);
        chk($sformatf("R%0d table step %0d", STEPS[k].rq, k), 64'(got), 64'(STEPS[k].ex));
      end
    end
    @(negedge clk);
    chk("R11 strobe drops after read", 64'(rv0), 64'd0);

    // R6 and R8: all eight vectors enabled, mask bit 1 set
    for (int i = 0; i < 8; i++) begin
      chk("R6 vector address", va0[64*i +: 64], 64'h0000_0001_C000_D000);
      chk("R6 vector data", 64'(vd0[32*i +: 32]), 64'(32'h00AA_CC00 + i));
      chk("R8 vector mask", 64'(vm0[i]), 64'(i == 1));
    end

    // R7: enabled log2 = 1, only vectors 0 and 1 in range
    do_wr(1'b0, 5'h02, 2'd1, 32'h0000_0411);
    @(negedge clk);
    for (int i = 0; i < 8; i++)
      chk("R7 vectors beyond count masked", 64'(vm0[i]), 64'(i != 0));

    // R5: extended data off, data cut to 16 bits
    do_wr(1'b0, 5'h02, 2'd1, 32'h0000_0031);
    do_wr(1'b0, 5'h0C, 2'd2, 32'h1234_5678);
    do_rd(1'b0, 5'h0C, 2'd2, got);
    chk("R5 short data readback", 64'(got), 64'h0000_5678);
    for (int i = 0; i < 8; i++)
      chk("R6 short data per vector", 64'(vd0[32*i +: 32]), 64'(32'h5678 + i));

    // R10 dword write at offset 0 clears enable, R9 all masked
    do_wr(1'b0, 5'h00, 2'd2, 32'h0000_0000);
    do_rd(1'b0, 5'h02, 2'd1, got);
    chk("R10 dword control write", 64'(got), 64'h0386);
    chk("R9 disable masks all", 64'(vm0), 64'hFF);
    do_wr(1'b0, 5'h00, 2'd2, 32'h0031_0000);
    @(negedge clk);
    chk("R10 dword write enables", 64'(vm0), 64'h02);

    // R9 reset clears state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 reset masks all", 64'(vm0), 64'hFF);
    do_rd(1'b0, 5'h02, 2'd1, got);
    chk("R9 reset clears enable", 64'(got), 64'h0386);
    do_rd(1'b0, 5'h0C, 2'd2, got);
    chk("R9 reset clears data", 64'(got), 64'h0);

    // second instance: no options, four vectors
    do_rd(1'b1, 5'h00, 2'd2, got);
    chk("R2 header without options", 64'(got), 64'h0004_0005);
    do_wr(1'b1, 5'h02, 2'd1, 32'h0000_0471);
    do_rd(1'b1, 5'h02, 2'd1, got);
    chk("R4 ext enable reads zero, R3 clamp to 2", 64'(got), 64'h0025);
    do_wr(1'b1, 5'h04, 2'd2, 32'hFEE0_1000);
    do_wr(1'b1, 5'h08, 2'd2, 32'h00AA_CC00);
    do_rd(1'b1, 5'h08, 2'd2, got);
    chk("R5 no ext cap keeps 16 bits", 64'(got), 64'h0000_CC00);
    do_wr(1'b1, 5'h0C, 2'd2, 32'hFFFF_FFFF);
    do_rd(1'b1, 5'h0C, 2'd2, got);
    chk("R1 offset 0xC beyond short length", 64'(got), 64'h0);
    @(negedge clk);
    chk("R1 ignored mask write leaves vectors", 64'(vm1), 64'h0);
    for (int i = 0; i < 4; i++) begin
      chk("R6 short address high zero", va1[64*i +: 64], 64'h0000_0000_FEE0_1000);
      chk("R6 short vector data", 64'(vd1[32*i +: 32]), 64'(32'hCC00 + i));
    end
    finish_run();
  end
endmodule